// File: doc/BRIEF.md
# Page-Mode Read Buffer

This block models the read side of a flash device whose array is organised in pages of four words. A read that starts a new page, or the first read after chip enable goes active, takes the slow random path. That access fetches all four words of the page in parallel into a local buffer. Any later read whose address falls in the same page is answered from that buffer on the short page path.

The requester holds chip enable active and presents a word address. The block watches that address on every clock edge. When the word for the current address is ready, it drives the word on `rd_data` and pulses `rd_valid` for one cycle. Dropping chip enable at any time abandons the access in flight and discards the buffered page. The array is a behavioural memory split into four banks, one per word position, so that a whole page can be read in a single access. The random and page latencies are parameters counted in clock cycles.

Top module: `page_read_buffer`

## Requirements
- R1: After synchronous reset, `rd_valid` is 0 and `rd_data` is 0.
- R2: The array word at word address A holds the low DW bits of (A * 0x9E3779B1) XOR 0xC3C3C3C3, computed in 32-bit arithmetic. Every `rd_valid` pulse carries the array word for the address it answers.
- R3: Chip enable may be active on the first edge that samples an address. On that first read, `rd_valid` is high after the RAND_LAT-th rising edge, counting the sampling edge as the first.
- R4: With a page loaded and chip enable held, a new address in that page (same bits AW-1:2) gives `rd_valid` after the PAGE_LAT-th edge, counting the edge that samples the new address.
- R5: A new address outside the loaded page takes the random latency RAND_LAT and replaces the buffered page.
- R6: Words of a loaded page may be read in any order, and each one is served on the page path.
- R7: Deasserting chip enable for even one cycle discards the loaded page. The next read, even to the same page, takes the random latency.
- R8: If chip enable drops while a random access is in flight, no `rd_valid` pulse follows. After re-enable, a full random access is counted from the re-enable edge.
- R9: If the address moves to another page while a random access is in flight, the access restarts. `rd_valid` comes RAND_LAT edges after the edge that samples the new address, with the word of the new page.
- R10: If the address moves within the same page while a random access is in flight, the access completes at its original time with the word for the new address.
- R11: If the address changes while a page-path read is pending, the pending read is dropped with no pulse. The page countdown restarts for the new address.
- R12: `rd_valid` is high for exactly one cycle per served address. While the address and chip enable are held, no further pulse comes and `rd_data` keeps its value.
- R13: While chip enable is low, `rd_valid` stays 0 whatever the address does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Chip enable, active high |
| rd_addr | input | AW | Word address of the current read |
| rd_data | output | DW | Word read, registered |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` good |

## Verification
The bench aims at the transitions where a read path can serve stale data or the wrong latency. These are a re-enable to the page last loaded (a design that kept its page valid would answer in PAGE_LAT cycles), a chip-enable drop in mid access (a leaking design would pulse `rd_valid` anyway), and a page change during a random fetch (a design that did not restart would hand back the old page's word early). It also moves the address inside the page during a fetch, where a design that restarted would be late and one that latched the old offset would return the wrong word. It moves the address again during a page-path read, where a design that did not drop the pending read would pulse for a word no longer asked for.

// File: rtl/pmr_pkg.sv
package pmr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RAND,
    ST_PAGE,
    ST_HOLD
  } pmr_state_e;

  // Array content for word address a (behavioural model of the flash cells).
  function automatic logic [31:0] pmr_fill_word(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'hC3C3_C3C3;
  endfunction

endpackage

// File: rtl/pmr_bank.sv
// One word column of the array: holds the word at offset BANK_ID of every page.
module pmr_bank #(
  parameter int DW      = 16,
  parameter int PIDX_W  = 6,
  parameter int OFF_W   = 2,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic [PIDX_W-1:0] rd_idx,
  output logic [DW-1:0]     rd_q
);
  localparam int DEPTH = 1 << PIDX_W;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    logic [31:0] w;
    for (int p = 0; p < DEPTH; p++) begin
      w = pmr_pkg::pmr_fill_word((32'(p) << OFF_W) | 32'(BANK_ID));
      mem[p] = w[DW-1:0];
    end
  end

  // Registered read so the column maps onto block RAM.
  always_ff @(posedge clk) begin
    rd_q <= mem[rd_idx];
  end

endmodule

// File: rtl/pmr_ctrl.sv
// Access sequencer: page tag, valid bit, latency countdown.
module pmr_ctrl #(
  parameter int AW       = 8,
  parameter int OFF_W    = 2,
  parameter int RAND_LAT = 8,
  parameter int PAGE_LAT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_en,
  input  logic [AW-1:0] rd_addr,
  output logic [AW-1:0] cur_addr,
  output logic          fill,
  output logic          serve
);
  import pmr_pkg::*;

  localparam int PG_W  = AW - OFF_W;
  localparam int MAXL  = (RAND_LAT > PAGE_LAT) ? RAND_LAT : PAGE_LAT;
  localparam int CNT_W = $clog2(MAXL);
  // Countdown loads: one edge is the sampling edge, one is the output register.
  localparam logic [CNT_W-1:0] RAND_LD = CNT_W'(RAND_LAT - 2);
  localparam logic [CNT_W-1:0] PAGE_LD = CNT_W'(PAGE_LAT - 2);

  pmr_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [PG_W-1:0]  tag;
  logic             pg_vld;

  logic changed, same_pg, hit, new_req;

  always_comb begin
    changed = (rd_addr != cur_addr);
    same_pg = (rd_addr[AW-1:OFF_W] == cur_addr[AW-1:OFF_W]);
    hit     = pg_vld && (rd_addr[AW-1:OFF_W] == tag);
    new_req = chip_en && ((state == ST_IDLE) ||
                          (changed && !((state == ST_RAND) && same_pg)));
    fill    = chip_en && !new_req && (state == ST_RAND) && (cnt == '0);
    serve   = chip_en && !new_req && (state == ST_PAGE) && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      cur_addr <= '0;
      tag      <= '0;
      pg_vld   <= 1'b0;
    end else if (!chip_en) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      pg_vld <= 1'b0;
    end else if (new_req) begin
      cur_addr <= rd_addr;
      if (hit) begin
        state <= ST_PAGE;
        cnt   <= PAGE_LD;
      end else begin
        state  <= ST_RAND;
        cnt    <= RAND_LD;
        pg_vld <= 1'b0;
      end
    end else begin
      case (state)
        ST_RAND: begin
          cur_addr <= rd_addr;  // offset may move inside the page
          if (cnt == '0) begin
            tag    <= cur_addr[AW-1:OFF_W];
            pg_vld <= 1'b1;
            state  <= ST_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PAGE: begin
          if (cnt == '0) state <= ST_HOLD;
          else           cnt   <= cnt - 1'b1;
        end
        default: ;
      endcase
    end
  end

  // R7
  pg_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !chip_en |=> !pg_vld);

  // R4
  serve_hit_chk: assert property (@(posedge clk) disable iff (rst)
    serve |-> pg_vld);

  // R3
  rand_count_chk: assert property (@(posedge clk) disable iff (rst)
    (chip_en && !new_req && state == ST_RAND && cnt != '0)
      |=> (cnt == $past(cnt) - 1'b1));

  // R9
  rand_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (chip_en && state == ST_RAND && !same_pg)
      |=> (state == ST_RAND && cnt == RAND_LD));

endmodule

// File: rtl/pmr_pagebuf.sv
// Page buffer and output register.
module pmr_pagebuf #(
  parameter int DW    = 16,
  parameter int WPP   = 4,
  parameter int OFF_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    chip_en,
  input  logic                    fill,
  input  logic                    serve,
  input  logic [OFF_W-1:0]        word_sel,
  input  logic [WPP-1:0][DW-1:0]  bank_q,
  output logic [DW-1:0]           rd_data,
  output logic                    rd_valid
);
  logic [WPP-1:0][DW-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q    <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= fill | serve;
      if (fill) begin
        buf_q   <= bank_q;
        rd_data <= bank_q[word_sel];
      end else if (serve) begin
        rd_data <= buf_q[word_sel];
      end
    end
  end

  // R12
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  // R13
  valid_en_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(chip_en));

endmodule

// File: rtl/page_read_buffer.sv
module page_read_buffer #(
  parameter int AW       = 8,
  parameter int DW       = 16,
  parameter int WPP      = 4,
  parameter int RAND_LAT = 8,   // at least 3
  parameter int PAGE_LAT = 2    // at least 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          chip_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int OFF_W  = $clog2(WPP);
  localparam int PIDX_W = AW - OFF_W;

  logic [AW-1:0]          cur_addr;
  logic                   fill, serve;
  logic [WPP-1:0][DW-1:0] bank_q;

  pmr_ctrl #(
    .AW(AW), .OFF_W(OFF_W), .RAND_LAT(RAND_LAT), .PAGE_LAT(PAGE_LAT)
  ) u_ctrl (
    .clk(clk), .rst(rst), .chip_en(chip_en), .rd_addr(rd_addr),
    .cur_addr(cur_addr), .fill(fill), .serve(serve)
  );

  for (genvar g = 0; g < WPP; g++) begin : g_bank
    pmr_bank #(
      .DW(DW), .PIDX_W(PIDX_W), .OFF_W(OFF_W), .BANK_ID(g)
    ) u_bank (
      .clk(clk), .rd_idx(cur_addr[AW-1:OFF_W]), .rd_q(bank_q[g])
    );
  end

  pmr_pagebuf #(
    .DW(DW), .WPP(WPP), .OFF_W(OFF_W)
  ) u_buf (
    .clk(clk), .rst(rst), .chip_en(chip_en), .fill(fill), .serve(serve),
    .word_sel(rd_addr[OFF_W-1:0]), .bank_q(bank_q),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

endmodule

// File: tb/tb_page_read_buffer.sv
module tb_page_read_buffer;
  localparam int AW = 8, DW = 16, RL = 8, PL = 2;

  logic clk = 1'b0, rst = 1'b1, chip_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  page_read_buffer #(.AW(AW), .DW(DW), .WPP(4), .RAND_LAT(RL), .PAGE_LAT(PL)) dut (
    .clk(clk), .rst(rst), .chip_en(chip_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid));

  // bit 8: 1 = page path expected, 0 = random path; bits 7:0 word address
  localparam logic [8:0] VEC [12] = '{
    9'h010, 9'h113, 9'h111, 9'h112, 9'h110, 9'h025,
    9'h127, 9'h124, 9'h010, 9'h111, 9'h0FF, 9'h1FC };

  function automatic logic [DW-1:0] exp_word(input int a);
    logic [31:0] w;
    w = (32'(a) * 32'h9E37_79B1) ^ 32'hC3C3_C3C3;
    return w[DW-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  // Counts edges until rd_valid, the first edge after the call being 1.
  task automatic wait_valid(output int lat, output logic [DW-1:0] d);
    lat = -1; d = '0;
    for (int n = 1; n <= 40; n++) begin
      step();
      if (rd_valid) begin lat = n; d = rd_data; return; end
    end
  endtask

  task automatic read_chk(input int a, input int exp_lat, input string req);
    int lat; logic [DW-1:0] d;
    rd_addr = AW'(a);
    wait_valid(lat, d);
    chk(lat == exp_lat, req, lat, exp_lat);
    chk(d == exp_word(a), {req, "/R2"}, d, exp_word(a));
  endtask

  task automatic quiet_chk(input int cyc, input string req);
    for (int n = 0; n < cyc; n++) begin
      step();
      chk(!rd_valid, req, rd_valid, 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat; logic [DW-1:0] d, held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!rd_valid && rd_data == '0, "R1", {rd_valid, rd_data}, 0);
    // R13: address wiggles with chip enable low
    for (int n = 0; n < 4; n++) begin
      rd_addr = AW'(8'h31 + n);
      step();
      chk(!rd_valid, "R13", rd_valid, 0);
    end

    // Table walk: R3 first entry, R4/R6 in-page, R5 page change, R12 hold
    for (int i = 0; i < 12; i++) begin
      rd_addr = VEC[i][7:0];
      chip_en = 1'b1;
      wait_valid(lat, d);
      chk(lat == (VEC[i][8] ? PL : RL), VEC[i][8] ? "R4/R6" : "R3/R5", lat,
          VEC[i][8] ? PL : RL);
      chk(d == exp_word(int'(VEC[i][7:0])), "R2", d, exp_word(int'(VEC[i][7:0])));
      held = rd_data;
      for (int n = 0; n < 3; n++) begin
        step();
        chk(!rd_valid && rd_data == held, "R12", {rd_valid, rd_data}, {1'b0, held});
      end
    end

    // R7: one-cycle drop, then same page again
    chip_en = 1'b0; step();
    chip_en = 1'b1;
    read_chk(8'hFC, RL, "R7");

    // R8: drop during a random access
    chip_en = 1'b0; step();
    chip_en = 1'b1; rd_addr = 8'h40;
    quiet_chk(3, "R8");
    chip_en = 1'b0;
    quiet_chk(4, "R8");
    chip_en = 1'b1;
    read_chk(8'h40, RL, "R8");

    // R9: page change mid random access
    chip_en = 1'b0; step();
    chip_en = 1'b1; rd_addr = 8'h50;
    quiet_chk(3, "R9");
    read_chk(8'h60, RL, "R9");
    read_chk(8'h61, PL, "R9");

    // R10: in-page offset change mid random access
    chip_en = 1'b0; step();
    chip_en = 1'b1; rd_addr = 8'h70;
    quiet_chk(3, "R10");
    read_chk(8'h72, RL - 3, "R10");
    read_chk(8'h71, PL, "R10");

    // R11: address moves while a page read is pending
    rd_addr = 8'h73;
    step();
    chk(!rd_valid, "R11", rd_valid, 0);
    read_chk(8'h70, PL, "R11");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule